// File: doc/BRIEF.md
# Integer Execution ALU with Overflow and Trap Flags

This block is the integer execution unit of a 32-bit load/store RISC pipeline. Each operation arrives as one beat carrying two register operands, a 16-bit immediate, a 5-bit shift count and an operation code. One cycle later the block returns a 32-bit result and three flags. The overflow and underflow flags report a signed range error on the checked add and subtract forms. The trap flag reports that a conditional trap compare held, or that a break was issued. The block only raises these flags. Acting on them is the job of the exception logic downstream.

Operations enter and leave on valid/ready streams. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The block holds a single output register. It can accept a new beat whenever that register is empty, or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` is low, so back-pressure passes straight upstream with no loss and no duplication.

The operation code is 5 bits wide and all 32 values are defined in the package `int_alu_pkg`. Every operation works on operand A (`in_a`) and on a second operand. The second operand is `in_b` for register forms and the extended immediate for immediate forms.

Top module: `int_exec_alu`

## Requirements
- R1: A beat accepted at a clock edge sets `out_valid` at that edge and drives its result on the following cycle. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs stay unchanged.
- R2: The wrapping add, subtract and add-immediate produce the result modulo 2^32 and never raise overflow or underflow.
- R3: The checked add and checked add-immediate return the wrapped sum. They raise overflow when the exact signed sum exceeds 0x7FFFFFFF and underflow when it is below -0x80000000. This includes equal operands such as 0x40000000 + 0x40000000.
- R4: The checked subtract returns the wrapped difference. It raises overflow when the exact signed A minus B exceeds 0x7FFFFFFF and underflow when it is below -0x80000000. This includes 0 minus 0x80000000, which raises overflow.
- R5: The register logical operations return A AND B, A OR B, A XOR B and NOT(A OR B).
- R6: AND, OR and XOR with an immediate zero-extend the 16-bit immediate. Load-upper places the immediate in bits 31:16 and clears bits 15:0.
- R7: The add-immediate and set-less-than-immediate forms sign-extend the immediate. The unsigned set-less-than-immediate sign-extends first and then compares both values as unsigned 32-bit numbers.
- R8: The set-less-than operations return 1 when A is less than the second operand, compared signed or unsigned as the code selects, and 0 otherwise.
- R9: The immediate shifts move `in_b` by `in_shamt`. The left shift and logical right shift fill with zeros, and the arithmetic right shift copies bit 31.
- R10: The variable shifts move `in_b` by `in_a[4:0]`. Bits 31:5 of `in_a` have no effect.
- R11: The six trap compares raise the trap flag on A >= B signed, A >= B unsigned, A < B signed, A < B unsigned, A == B and A != B. Break always raises it. All trap operations return a zero result.
- R12: After reset `out_valid` is 0 and `in_ready` is 1. The trap flag is raised only by trap operations. Overflow and underflow are raised only by the checked add forms and never together. The reserved code 31 returns zero with all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_op | input | 5 | Operation code, values from `int_alu_pkg::alu_op_e` |
| in_a | input | 32 | Operand A; also the variable shift count source |
| in_b | input | 32 | Operand B; the value moved by shifts |
| in_imm | input | 16 | Immediate for immediate forms |
| in_shamt | input | 5 | Count for immediate shifts |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Operation result |
| out_ovf | output | 1 | Signed result above maximum (checked forms) |
| out_unf | output | 1 | Signed result below minimum (checked forms) |
| out_trap | output | 1 | Trap condition held or break issued |

## Verification
The bench targets the signed range edges of checked add and subtract. The cases are 0x7FFFFFFF + 1, 0x80000000 + 0xFFFFFFFF, 0 minus 0x80000000 and equal operands. A design that tested the sign of A against zero, or that required differing bit patterns, would miss exactly these flags. Immediate extension is exercised with bit 15 set. A wrong choice between sign and zero extension shows up as a wrong upper half in logical immediates and as an inverted verdict in unsigned set-less-than-immediate. Variable shifts are driven with junk in bits 31:5 of A, and arithmetic right shift with negative values, to catch counts that use too many bits and fills with the wrong value. A stall sequence holds `out_ready` low with a second beat waiting, which exposes a block that overwrites or drops a result under back-pressure.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int SH_W   = $clog2(DATA_W);

  typedef enum logic [4:0] {
    OP_ADD_T    = 5'd0,
    OP_ADD_W    = 5'd1,
    OP_SUB_T    = 5'd2,
    OP_SUB_W    = 5'd3,
    OP_AND      = 5'd4,
    OP_OR       = 5'd5,
    OP_XOR      = 5'd6,
    OP_NOR      = 5'd7,
    OP_SLT_S    = 5'd8,
    OP_SLT_U    = 5'd9,
    OP_ADDI_T   = 5'd10,
    OP_ADDI_W   = 5'd11,
    OP_SLTI_S   = 5'd12,
    OP_SLTI_U   = 5'd13,
    OP_ANDI     = 5'd14,
    OP_ORI      = 5'd15,
    OP_XORI     = 5'd16,
    OP_LUI      = 5'd17,
    OP_SHL_I    = 5'd18,
    OP_SHR_I    = 5'd19,
    OP_SRA_I    = 5'd20,
    OP_SHL_V    = 5'd21,
    OP_SHR_V    = 5'd22,
    OP_SRA_V    = 5'd23,
    OP_TRAP_GE  = 5'd24,
    OP_TRAP_GEU = 5'd25,
    OP_TRAP_LT  = 5'd26,
    OP_TRAP_LTU = 5'd27,
    OP_TRAP_EQ  = 5'd28,
    OP_TRAP_NE  = 5'd29,
    OP_BRK      = 5'd30,
    OP_RSVD     = 5'd31
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] result;
    logic              ovf;
    logic              unf;
    logic              trap;
  } alu_out_t;
endpackage

// File: rtl/int_alu_opnd.sv
`timescale 1ns/1ps
// Selects the second operand: register B or an extended immediate.
module int_alu_opnd
  import int_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   b,
  input  logic [IW-1:0]   imm,
  output logic [DW-1:0]   opnd_b
);
  localparam int PAD = DW - IW;

  logic [DW-1:0] imm_sx, imm_zx;
  assign imm_sx = {{PAD{imm[IW-1]}}, imm};
  assign imm_zx = {{PAD{1'b0}}, imm};

  always_comb begin
    case (op)
      OP_ADDI_T, OP_ADDI_W, OP_SLTI_S, OP_SLTI_U: opnd_b = imm_sx;
      OP_ANDI, OP_ORI, OP_XORI:                   opnd_b = imm_zx;
      OP_LUI:                                     opnd_b = {imm, {PAD{1'b0}}};
      default:                                    opnd_b = b;
    endcase
  end
endmodule

// File: rtl/int_alu_addsub.sv
`timescale 1ns/1ps
// Single adder for add and subtract, with signed range flags.
module int_alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          checked,
  output logic [DW-1:0] sum,
  output logic          ovf,
  output logic          unf
);
  logic [DW-1:0] b_eff;
  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(DW-1){1'b0}}, sub};

  // Same-signed effective addends whose sum sign flips are out of range.
  assign ovf = checked & ~a[DW-1] & ~b_eff[DW-1] &  sum[DW-1];
  assign unf = checked &  a[DW-1] &  b_eff[DW-1] & ~sum[DW-1];
endmodule

// File: rtl/int_alu_shift.sv
`timescale 1ns/1ps
// Logarithmic right shifter; left shifts reuse it through bit reversal.
module int_alu_shift #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input  logic [DW-1:0] val,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [DW-1:0] res
);
  logic [DW-1:0] val_rev, pre, out_rev;
  logic [DW-1:0] stg [0:SW];
  logic          fill;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign val_rev[i] = val[DW-1-i];
    assign out_rev[i] = stg[SW][DW-1-i];
  end

  assign pre    = left ? val_rev : val;
  assign fill   = arith & ~left & val[DW-1];
  assign stg[0] = pre;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][DW-1:STEP]} : stg[s];
  end

  assign res = left ? out_rev : stg[SW];
endmodule

// File: rtl/int_alu_cmp.sv
`timescale 1ns/1ps
// Magnitude and equality compare shared by set-less-than and traps.
module int_alu_cmp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          lt_s,
  output logic          lt_u,
  output logic          eq
);
  assign lt_u = a < b;
  assign lt_s = (a[DW-1] != b[DW-1]) ? a[DW-1] : lt_u;
  assign eq   = a == b;
endmodule

// File: rtl/int_exec_alu.sv
`timescale 1ns/1ps
module int_exec_alu
  import int_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W,
  parameter int SW = SH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [4:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [IW-1:0] in_imm,
  input  logic [SW-1:0] in_shamt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_ovf,
  output logic          out_unf,
  output logic          out_trap
);
  alu_op_e op;
  assign op = alu_op_e'(in_op);

  logic [DW-1:0] opnd_b, sum, sh_res;
  logic          ovf, unf, lt_s, lt_u, eq;
  logic          is_sub, is_checked, sh_left, sh_arith, sh_var;
  logic [SW-1:0] sh_amt;

  int_alu_opnd #(.DW(DW), .IW(IW)) u_opnd (
    .op(op), .b(in_b), .imm(in_imm), .opnd_b(opnd_b)
  );

  assign is_sub     = (op == OP_SUB_T) || (op == OP_SUB_W);
  assign is_checked = (op == OP_ADD_T) || (op == OP_SUB_T) || (op == OP_ADDI_T);

  int_alu_addsub #(.DW(DW)) u_addsub (
    .a(in_a), .b(opnd_b), .sub(is_sub), .checked(is_checked),
    .sum(sum), .ovf(ovf), .unf(unf)
  );

  int_alu_cmp #(.DW(DW)) u_cmp (
    .a(in_a), .b(opnd_b), .lt_s(lt_s), .lt_u(lt_u), .eq(eq)
  );

  assign sh_var   = (op == OP_SHL_V) || (op == OP_SHR_V) || (op == OP_SRA_V);
  assign sh_left  = (op == OP_SHL_I) || (op == OP_SHL_V);
  assign sh_arith = (op == OP_SRA_I) || (op == OP_SRA_V);
  assign sh_amt   = sh_var ? in_a[SW-1:0] : in_shamt;

  int_alu_shift #(.DW(DW), .SW(SW)) u_shift (
    .val(in_b), .amt(sh_amt), .left(sh_left), .arith(sh_arith), .res(sh_res)
  );

  alu_out_t nxt;

  always_comb begin
    nxt = '0;
    case (op)
      OP_ADD_T, OP_SUB_T, OP_ADDI_T: begin
        nxt.result = sum;
        nxt.ovf    = ovf;
        nxt.unf    = unf;
      end
      OP_ADD_W, OP_SUB_W, OP_ADDI_W: nxt.result = sum;
      OP_AND, OP_ANDI:               nxt.result = in_a & opnd_b;
      OP_OR,  OP_ORI:                nxt.result = in_a | opnd_b;
      OP_XOR, OP_XORI:               nxt.result = in_a ^ opnd_b;
      OP_NOR:                        nxt.result = ~(in_a | opnd_b);
      OP_LUI:                        nxt.result = opnd_b;
      OP_SLT_S, OP_SLTI_S:           nxt.result = {{(DW-1){1'b0}}, lt_s};
      OP_SLT_U, OP_SLTI_U:           nxt.result = {{(DW-1){1'b0}}, lt_u};
      OP_SHL_I, OP_SHR_I, OP_SRA_I,
      OP_SHL_V, OP_SHR_V, OP_SRA_V:  nxt.result = sh_res;
      OP_TRAP_GE:                    nxt.trap = ~lt_s;
      OP_TRAP_GEU:                   nxt.trap = ~lt_u;
      OP_TRAP_LT:                    nxt.trap = lt_s;
      OP_TRAP_LTU:                   nxt.trap = lt_u;
      OP_TRAP_EQ:                    nxt.trap = eq;
      OP_TRAP_NE:                    nxt.trap = ~eq;
      OP_BRK:                        nxt.trap = 1'b1;
      default:                       nxt = '0;
    endcase
  end

  // Single output register stage with pass-through back-pressure.
  alu_out_t held;
  logic     take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        held      <= nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_result = held.result;
  assign out_ovf    = held.ovf;
  assign out_unf    = held.unf;
  assign out_trap   = held.trap;
endmodule

// File: rtl/int_exec_alu_chk.sv
`timescale 1ns/1ps
module int_exec_alu_chk
  import int_alu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [4:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_ovf,
  input logic        out_unf,
  input logic        out_trap
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_ovf) && $stable(out_unf) && $stable(out_trap)));

  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_ADD_W || in_op == OP_SUB_W || in_op == OP_ADDI_W))
      |=> (!out_ovf && !out_unf));

  // R11
  brk_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_BRK) |=> (out_trap && out_result == 32'd0));

  // R12
  no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op < OP_TRAP_GE || in_op == OP_RSVD)) |=> !out_trap);

  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ovf && out_unf));
endmodule

bind int_exec_alu int_exec_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_ovf(out_ovf), .out_unf(out_unf),
  .out_trap(out_trap)
);

// File: tb/int_exec_alu_bench.sv
`timescale 1ns/1ps
module int_exec_alu_bench;
  import int_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = 5'd0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_ovf, out_unf, out_trap;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  int_exec_alu u_int_exec_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_shamt(in_shamt), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_ovf(out_ovf), .out_unf(out_unf),
    .out_trap(out_trap)
  );

  function automatic string tag_of(input logic [4:0] op);
    case (alu_op_e'(op))
      OP_ADD_W, OP_SUB_W, OP_ADDI_W:              return "R2";
      OP_ADD_T, OP_ADDI_T:                        return "R3";
      OP_SUB_T:                                   return "R4";
      OP_AND, OP_OR, OP_XOR, OP_NOR:              return "R5";
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI:           return "R6";
      OP_SLTI_S, OP_SLTI_U:                       return "R7";
      OP_SLT_S, OP_SLT_U:                         return "R8";
      OP_SHL_I, OP_SHR_I, OP_SRA_I:               return "R9";
      OP_SHL_V, OP_SHR_V, OP_SRA_V:               return "R10";
      OP_RSVD:                                    return "R12";
      default:                                    return "R11";
    endcase
  endfunction

  // Reference model written from the requirements: {result, ovf, unf, trap}.
  function automatic logic [34:0] model(input logic [4:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh);
    logic [31:0] r = '0, sx, zx;
    logic ov = 1'b0, un = 1'b0, tr = 1'b0;
    longint ex;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0, imm};
    case (alu_op_e'(op))
      OP_ADD_T, OP_ADDI_T: begin
        logic [31:0] bb;
        bb = (alu_op_e'(op) == OP_ADD_T) ? b : sx;
        r  = a + bb;
        ex = longint'($signed(a)) + longint'($signed(bb));
        ov = ex > 64'sd2147483647;
        un = ex < -64'sd2147483648;
      end
      OP_SUB_T: begin
        r  = a - b;
        ex = longint'($signed(a)) - longint'($signed(b));
        ov = ex > 64'sd2147483647;
        un = ex < -64'sd2147483648;
      end
      OP_ADD_W:    r = a + b;
      OP_SUB_W:    r = a - b;
      OP_ADDI_W:   r = a + sx;
      OP_AND:      r = a & b;
      OP_OR:       r = a | b;
      OP_XOR:      r = a ^ b;
      OP_NOR:      r = ~(a | b);
      OP_ANDI:     r = a & zx;
      OP_ORI:      r = a | zx;
      OP_XORI:     r = a ^ zx;
      OP_LUI:      r = {imm, 16'h0};
      OP_SLT_S:    r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      OP_SLT_U:    r = (a < b) ? 32'd1 : 32'd0;
      OP_SLTI_S:   r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      OP_SLTI_U:   r = (a < sx) ? 32'd1 : 32'd0;
      OP_SHL_I:    r = b << sh;
      OP_SHR_I:    r = b >> sh;
      OP_SRA_I:    r = $unsigned($signed(b) >>> sh);
      OP_SHL_V:    r = b << a[4:0];
      OP_SHR_V:    r = b >> a[4:0];
      OP_SRA_V:    r = $unsigned($signed(b) >>> a[4:0]);
      OP_TRAP_GE:  tr = $signed(a) >= $signed(b);
      OP_TRAP_GEU: tr = a >= b;
      OP_TRAP_LT:  tr = $signed(a) < $signed(b);
      OP_TRAP_LTU: tr = a < b;
      OP_TRAP_EQ:  tr = a == b;
      OP_TRAP_NE:  tr = a != b;
      OP_BRK:      tr = 1'b1;
      default:     r = '0;
    endcase
    return {r, ov, un, tr};
  endfunction

  task automatic report(input string tag, input logic [34:0] got, input logic [34:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got res=%h o/u/t=%b%b%b expected res=%h o/u/t=%b%b%b",
               tag, got[34:3], got[2], got[1], got[0], exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // One beat in, result checked on the following cycle (R1 latency).
  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic [4:0] sh);
    logic [34:0] exp;
    exp = model(op, a, b, imm, sh);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm; in_shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
    report("R1", {34'd0, out_valid}, {34'd0, 1'b1});
    report(tag_of(op), {out_result, out_ovf, out_unf, out_trap}, exp);
  endtask

  task automatic t_reset();
    // R12: reset state
    report("R12", {33'd0, out_valid, in_ready}, {33'd0, 1'b0, 1'b1});
  endtask

  task automatic t_wrap();
    drive(OP_ADD_W, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);          // R2
    drive(OP_SUB_W, 32'h0, 32'h80000000, 16'h0, 5'd0);          // R2
    drive(OP_ADDI_W, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0);      // R2
  endtask

  task automatic t_checked_add();
    drive(OP_ADD_T, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);          // R3 overflow
    drive(OP_ADD_T, 32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0);   // R3 underflow
    drive(OP_ADD_T, 32'h40000000, 32'h40000000, 16'h0, 5'd0);   // R3 equal operands
    drive(OP_ADD_T, 32'h80000000, 32'h80000000, 16'h0, 5'd0);   // R3
    drive(OP_ADDI_T, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0);      // R3 immediate
    drive(OP_ADDI_T, 32'h80000000, 32'h0, 16'hFFFF, 5'd0);      // R3 immediate
  endtask

  task automatic t_checked_sub();
    drive(OP_SUB_T, 32'h0, 32'h80000000, 16'h0, 5'd0);          // R4 zero minus min
    drive(OP_SUB_T, 32'h80000000, 32'h1, 16'h0, 5'd0);          // R4 underflow
    drive(OP_SUB_T, 32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd0);   // R4 in range
    drive(OP_SUB_T, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0);   // R4 overflow
  endtask

  task automatic t_logic_imm();
    drive(OP_NOR, 32'h0F0F0000, 32'h000000F0, 16'h0, 5'd0);     // R5
    drive(OP_ANDI, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0);        // R6 zero-extend
    drive(OP_ORI, 32'h00000000, 32'h0, 16'hF000, 5'd0);         // R6
    drive(OP_XORI, 32'hFFFF0000, 32'h0, 16'hFFFF, 5'd0);        // R6
    drive(OP_LUI, 32'h12345678, 32'h0, 16'hBEEF, 5'd0);         // R6
    drive(OP_SLTI_U, 32'h00001000, 32'h0, 16'hFFFF, 5'd0);      // R7 sign-extend then unsigned
    drive(OP_SLTI_U, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd0);      // R7
    drive(OP_SLTI_S, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0);      // R7
    drive(OP_SLT_S, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);   // R8
    drive(OP_SLT_U, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);   // R8
  endtask

  task automatic t_shifts();
    drive(OP_SRA_I, 32'h0, 32'h80000010, 16'h0, 5'd4);          // R9
    drive(OP_SHR_I, 32'h0, 32'h80000010, 16'h0, 5'd31);         // R9
    drive(OP_SHL_I, 32'h0, 32'h80000011, 16'h0, 5'd1);          // R9
    drive(OP_SRA_V, 32'hFFFFFFE3, 32'h80000000, 16'h0, 5'd0);   // R10 upper bits junk
    drive(OP_SHL_V, 32'h12345620, 32'h00000001, 16'h0, 5'd7);   // R10 count 0
    drive(OP_SHR_V, 32'hABCDEF1F, 32'hFFFFFFFF, 16'h0, 5'd2);   // R10
  endtask

  task automatic t_traps();
    drive(OP_TRAP_GE, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0); // R11
    drive(OP_TRAP_GEU, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);// R11
    drive(OP_TRAP_LT, 32'h5, 32'h5, 16'h0, 5'd0);               // R11
    drive(OP_TRAP_LTU, 32'h0, 32'hFFFFFFFF, 16'h0, 5'd0);       // R11
    drive(OP_TRAP_EQ, 32'hDEADBEEF, 32'hDEADBEEF, 16'h0, 5'd0); // R11
    drive(OP_TRAP_NE, 32'hDEADBEEF, 32'hDEADBEEF, 16'h0, 5'd0); // R11
    drive(OP_BRK, 32'h0, 32'h0, 16'h0, 5'd0);                   // R11
    drive(OP_RSVD, 32'hFFFFFFFF, 32'h1, 16'hFFFF, 5'd3);        // R12
  endtask

  task automatic t_boundary();
    logic [31:0] edges [4];
    edges[0] = 32'h7FFFFFFF; edges[1] = 32'h80000000;
    edges[2] = 32'hFFFFFFFF; edges[3] = 32'h00000000;
    for (int k = 0; k < 32; k++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(5'(k), edges[i], edges[j], edges[j][15:0] ^ 16'h8000, edges[i][4:0]);
  endtask

  task automatic t_random();
    for (int k = 0; k < 32; k++)
      for (int n = 0; n < 40; n++)
        drive(5'(k), $urandom, $urandom, 16'($urandom), 5'($urandom));
  endtask

  task automatic t_stall();
    logic [34:0] exp_a, exp_b;
    exp_a = model(OP_ADD_W, 32'd1, 32'd2, 16'h0, 5'd0);
    exp_b = model(OP_XOR, 32'hF0F0F0F0, 32'hFFFF0000, 16'h0, 5'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = OP_ADD_W; in_a = 32'd1; in_b = 32'd2;
    @(negedge clk);
    in_op = OP_XOR; in_a = 32'hF0F0F0F0; in_b = 32'hFFFF0000;
    // R1: stalled, first result present and upstream blocked
    report("R1", {out_result, out_valid, in_ready, 1'b0}, {exp_a[34:3], 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    report("R1", {out_result, out_ovf, out_unf, out_trap}, exp_a);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    report("R1", {out_result, out_ovf, out_unf, out_trap}, exp_b);
    report("R1", {34'd0, out_valid}, {34'd0, 1'b1});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R1: watchdog expired, got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wrap();
    t_checked_add();
    t_checked_sub();
    t_logic_imm();
    t_shifts();
    t_traps();
    t_stall();
    t_boundary();
    t_random();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule